// File: doc/BRIEF.md
# Gated Differential Clock Fan-out Controller

The block takes one reference clock and produces eight true/complement clock pairs, each with its own drive-enable flag that stands in for a tri-state driver. A running pair follows a shared phase that toggles on every reference edge. A divide-select bit can halve that rate so the phase toggles on every second edge. Each pair can be held off by its own pin enable and its own register enable. A global power-down pin and a global stop pin can park pairs in one of two stopped states: driven (true high, complement low) or released (both lines undriven).

The enable, stop, power-down and polarity pins are asynchronous. They pass through a two-flop synchronizer before use. When the polarity pin is asserted, the sense of the eight enable pins, the stop pin and the power-down pin is inverted. The register controls arrive as plain synchronous inputs from a register block that sits outside this design.

No pair ever emits a shortened pulse. A pair only changes between running, parked and off at the edge that ends a low half-period of the shared phase.

Top module: `clkgate_fanout`

## Requirements
- R1: When `oe_pol` is 1, the block treats `oe_pin`, `stop_pin` and `pwrdn_pin` as inverted: an enable pin is active at 0, and stop and power-down are asserted at 1. When `oe_pol` is 0, an enable pin is active at 1, and stop and power-down are asserted at 0.
- R2: While power-down is asserted, every enabled pair is parked. `cfg_pdn_tri` = 0 parks it driven and `cfg_pdn_tri` = 1 parks it released. Power-down takes priority over stop.
- R3: While stop is asserted, only enabled pairs whose `cfg_stop_en` bit is 1 are parked, in the manner chosen by `cfg_stop_tri`. Pairs whose bit is 0 keep running.
- R4: A pair parked driven shows `out`=1, `out_n`=0 and `drive_en`=1. A pair parked released shows `drive_en`=0 with `out`=0 and `out_n`=0.
- R5: A pair is enabled only when its effective pin enable and its `cfg_oe` bit are both 1. A pair that is not enabled is off (`drive_en`=0, `out`=0, `out_n`=0), regardless of stop or power-down.
- R6: With `cfg_div_n` = 1, a running pair changes level on every `clk_in` cycle. `out_n` is always the inverse of `out`, and all running pairs are in phase.
- R7: With `cfg_div_n` = 0, a running pair changes level on every second `clk_in` cycle, never on two consecutive cycles.
- R8: A pair changes state only at the edge that ends a low half-period of the shared phase. Every high or low level a pair shows therefore lasts at least one full half-period.
- R9: While `rst` is high, and on the first cycle after it falls, every pair is off (`drive_en`=0, `out`=0, `out_n`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_pin | input | 8 | Asynchronous per-pair enable pins |
| oe_pol | input | 1 | Asynchronous polarity-select pin |
| stop_pin | input | 1 | Asynchronous stop pin (active low when not inverted) |
| pwrdn_pin | input | 1 | Asynchronous power-down pin (active low when not inverted) |
| cfg_oe | input | 8 | Register enable per pair |
| cfg_stop_en | input | 8 | Register stop eligibility per pair |
| cfg_div_n | input | 1 | Divide-select, 0 halves the output rate |
| cfg_stop_tri | input | 1 | Stopped state for stop: 0 driven, 1 released |
| cfg_pdn_tri | input | 1 | Stopped state for power-down: 0 driven, 1 released |
| out | output | 8 | True clock lines |
| out_n | output | 8 | Complement clock lines |
| drive_en | output | 8 | Line driver enable per pair, 0 means undriven |

## Verification
The assertions take the register inputs to be synchronous to `clk_in`, and they take reset to be held for at least one edge before any check counts. The half-rate property only looks at toggles that follow at least two cycles in divide mode. The bench therefore changes register inputs and reset just after a rising edge. It moves the asynchronous pins freely, but away from the sampling point. It holds each configuration for at least twelve cycles before sampling, which covers synchronizer latency plus the wait for a low-phase boundary.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [1:0] {
        LS_OFF      = 2'd0,
        LS_RUN      = 2'd1,
        LS_PARK_HI  = 2'd2,
        LS_PARK_TRI = 2'd3
    } lane_state_e;

    typedef struct packed {
        logic div_n;
        logic stop_tri;
        logic pdn_tri;
    } gate_cfg_t;

    typedef struct packed {
        logic pwr_down;
        logic stop;
    } gate_ctl_t;

    typedef struct packed {
        logic tru;
        logic cmp;
        logic drv;
    } pair_drive_t;

    function automatic lane_state_e lane_request(
        input logic      enabled,
        input logic      stop_elig,
        input gate_ctl_t ctl,
        input gate_cfg_t cfg
    );
        if (!enabled)
            return LS_OFF;
        if (ctl.pwr_down)
            return cfg.pdn_tri ? LS_PARK_TRI : LS_PARK_HI;
        if (ctl.stop && stop_elig)
            return cfg.stop_tri ? LS_PARK_TRI : LS_PARK_HI;
        return LS_RUN;
    endfunction

    function automatic pair_drive_t pair_levels(
        input lane_state_e st,
        input logic        phase
    );
        pair_drive_t p;
        case (st)
            LS_RUN:     p = '{tru: phase, cmp: !phase, drv: 1'b1};
            LS_PARK_HI: p = '{tru: 1'b1,  cmp: 1'b0,   drv: 1'b1};
            default:    p = '{tru: 1'b0,  cmp: 1'b0,   drv: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++)
                stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clkgate_phase.sv
module clkgate_phase (
    input  logic clk,
    input  logic rst,
    input  logic div_n,
    output logic ph,
    output logic ph_nxt,
    output logic upd
);
    logic pre_q;
    logic flip;

    assign flip   = div_n | pre_q;
    assign ph_nxt = ph ^ flip;
    assign upd    = !ph && flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= 1'b0;
            pre_q <= 1'b0;
        end else begin
            ph    <= ph_nxt;
            pre_q <= !pre_q;
        end
    end

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        div_n |=> (ph != $past(ph)));  // R6
    AST_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
        (!div_n && !$past(div_n) && (ph != $past(ph))) |=> (ph == $past(ph)));  // R7
endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane
    import clkgate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        upd,
    input  logic        ph,
    input  logic        ph_nxt,
    input  lane_state_e req,
    output logic        tru,
    output logic        cmp,
    output logic        drv
);
    lane_state_e state_q;
    lane_state_e state_d;
    pair_drive_t lv;

    always_comb begin
        state_d = upd ? req : state_q;
        lv      = pair_levels(state_d, ph_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_OFF;
            tru     <= 1'b0;
            cmp     <= 1'b0;
            drv     <= 1'b0;
        end else begin
            state_q <= state_d;
            tru     <= lv.tru;
            cmp     <= lv.cmp;
            drv     <= lv.drv;
        end
    end

    AST_CHANGE_AT_LOW_END: assert property (@(posedge clk) disable iff (rst)
        (state_q != $past(state_q)) |-> (ph && !$past(ph)));  // R8
    AST_RUN_INVERSE: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_RUN) |-> (drv && (cmp == !tru) && (tru == ph)));  // R6
    AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !drv |-> (!tru && !cmp));  // R4
    AST_PARK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_PARK_HI) |-> (drv && tru && !cmp));  // R4
endmodule

// File: rtl/clkgate_fanout.sv
module clkgate_fanout
    import clkgate_pkg::*;
#(
    parameter int N_OUT       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic [N_OUT-1:0] oe_pin,
    input  logic             oe_pol,
    input  logic             stop_pin,
    input  logic             pwrdn_pin,
    input  logic [N_OUT-1:0] cfg_oe,
    input  logic [N_OUT-1:0] cfg_stop_en,
    input  logic             cfg_div_n,
    input  logic             cfg_stop_tri,
    input  logic             cfg_pdn_tri,
    output logic [N_OUT-1:0] out,
    output logic [N_OUT-1:0] out_n,
    output logic [N_OUT-1:0] drive_en
);
    localparam int SW = N_OUT + 3;

    logic [SW-1:0]    pins_raw;
    logic [SW-1:0]    pins_s;
    logic [N_OUT-1:0] oe_s;
    logic             pol_s;
    logic             stop_s;
    logic             pdn_s;
    logic [N_OUT-1:0] oe_eff;
    gate_ctl_t        ctl;
    gate_cfg_t        cfg;
    logic             ph;
    logic             ph_nxt;
    logic             upd;

    assign pins_raw = {oe_pol, stop_pin, pwrdn_pin, oe_pin};

    clkgate_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_in),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign {pol_s, stop_s, pdn_s, oe_s} = pins_s;
    assign oe_eff       = oe_s ^ {N_OUT{pol_s}};
    assign ctl.stop     = !(stop_s ^ pol_s);
    assign ctl.pwr_down = !(pdn_s ^ pol_s);
    assign cfg          = '{div_n: cfg_div_n, stop_tri: cfg_stop_tri, pdn_tri: cfg_pdn_tri};

    clkgate_phase u_phase (
        .clk    (clk_in),
        .rst    (rst),
        .div_n  (cfg.div_n),
        .ph     (ph),
        .ph_nxt (ph_nxt),
        .upd    (upd)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        lane_state_e req;
        assign req = lane_request(oe_eff[g] && cfg_oe[g], cfg_stop_en[g], ctl, cfg);

        clkgate_lane u_lane (
            .clk    (clk_in),
            .rst    (rst),
            .upd    (upd),
            .ph     (ph),
            .ph_nxt (ph_nxt),
            .req    (req),
            .tru    (out[g]),
            .cmp    (out_n[g]),
            .drv    (drive_en[g])
        );
    end

    AST_RESET_OFF: assert property (@(posedge clk_in)
        rst |=> (drive_en == '0 && out == '0 && out_n == '0));  // R9
endmodule

// File: tb/clkgate_fanout_test.sv
`timescale 1ns/1ps
module clkgate_fanout_test;
    localparam int NV = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] oe_pin, cfg_oe, cfg_stop_en;
    logic       oe_pol, stop_pin, pwrdn_pin, cfg_div_n, cfg_stop_tri, cfg_pdn_tri;
    logic [7:0] out, out_n, drive_en;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    clkgate_fanout uut (
        .clk_in(clk), .rst(rst), .oe_pin(oe_pin), .oe_pol(oe_pol),
        .stop_pin(stop_pin), .pwrdn_pin(pwrdn_pin), .cfg_oe(cfg_oe),
        .cfg_stop_en(cfg_stop_en), .cfg_div_n(cfg_div_n),
        .cfg_stop_tri(cfg_stop_tri), .cfg_pdn_tri(cfg_pdn_tri),
        .out(out), .out_n(out_n), .drive_en(drive_en)
    );

    // row: oe_pin, pol, stop, pwrdn, cfg_oe, stop_en, div_n, stop_tri, pdn_tri, exp_run, exp_park
    localparam logic [45:0] VEC [NV] = '{
        {8'hFF,1'b0,1'b1,1'b1,8'hFF,8'h00,1'b1,1'b0,1'b0,8'hFF,8'h00}, // R6 all running
        {8'hFF,1'b0,1'b1,1'b1,8'hFF,8'h00,1'b0,1'b0,1'b0,8'hFF,8'h00}, // R7 halved
        {8'hFF,1'b0,1'b0,1'b1,8'hFF,8'h0F,1'b1,1'b0,1'b0,8'hF0,8'h0F}, // R3 driven stop
        {8'hFF,1'b0,1'b0,1'b1,8'hFF,8'h0F,1'b1,1'b1,1'b0,8'hF0,8'h00}, // R4 released stop
        {8'hFF,1'b0,1'b1,1'b0,8'hFF,8'h00,1'b1,1'b0,1'b0,8'h00,8'hFF}, // R2 driven power-down
        {8'hFF,1'b0,1'b0,1'b0,8'hFF,8'hFF,1'b1,1'b0,1'b1,8'h00,8'h00}, // R2 released power-down
        {8'hA5,1'b0,1'b1,1'b1,8'h3C,8'h00,1'b1,1'b0,1'b0,8'h24,8'h00}, // R5 pin and register
        {8'h5A,1'b1,1'b1,1'b0,8'hFF,8'hF0,1'b0,1'b0,1'b0,8'h05,8'hA0}, // R1 inverted sense
        {8'h00,1'b1,1'b0,1'b1,8'hFF,8'h00,1'b1,1'b0,1'b0,8'h00,8'hFF}, // R1 inverted power-down
        {8'h0F,1'b0,1'b1,1'b0,8'hFF,8'h00,1'b1,1'b0,1'b0,8'h00,8'h0F}  // R5 off beats power-down
    };

    function automatic string row_tag(input int r);
        case (r)
            0: return "R6"; 1: return "R7"; 2: return "R3"; 3: return "R4";
            4: return "R2"; 5: return "R2"; 6: return "R5"; 7: return "R1";
            8: return "R1"; default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [45:0] v);
        {oe_pin, oe_pol, stop_pin, pwrdn_pin, cfg_oe, cfg_stop_en,
         cfg_div_n, cfg_stop_tri, cfg_pdn_tri} = v[45:16];
    endtask

    // glitch monitor on pair 0
    bit   mon_on = 0;
    bit   seg_ok = 0;
    logic prev0 = 1'b0;
    int   seg_len = 0;
    int   half = 1;
    always @(negedge clk) begin
        if (mon_on) begin
            if (out[0] !== prev0) begin
                if (seg_ok) chk(seg_len >= half, "R8 pulse width", seg_len, half);
                seg_ok  = 1;
                seg_len = 1;
            end else begin
                seg_len++;
            end
            prev0 = out[0];
        end else begin
            seg_ok = 0;
            prev0  = out[0];
        end
    end

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] so [8];
        logic [7:0] sn [8];
        logic [7:0] sd [8];
        logic [7:0] run, park;
        int tr;
        bit consec, inph;

        rst = 1'b1;
        apply(VEC[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(drive_en == 8'h00 && out == 8'h00 && out_n == 8'h00, "R9 in reset",
            {drive_en, out, out_n}, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(drive_en == 8'h00 && out == 8'h00 && out_n == 8'h00, "R9 after release",
            {drive_en, out, out_n}, 0);

        for (int r = 0; r < NV; r++) begin
            @(posedge clk); #1 apply(VEC[r]);
            run  = VEC[r][15:8];
            park = VEC[r][7:0];
            repeat (12) @(posedge clk);
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                so[k] = out; sn[k] = out_n; sd[k] = drive_en;
            end
            for (int k = 0; k < 8; k++) begin
                chk(sd[k] == (run | park), row_tag(r), sd[k], run | park);
                chk((so[k] & park) == park && (sn[k] & park) == 8'h00, row_tag(r),
                    {so[k], sn[k]}, {park, 8'h00});
                chk((so[k] & ~(run | park)) == 8'h00 && (sn[k] & ~(run | park)) == 8'h00,
                    row_tag(r), {so[k], sn[k]}, 0);
                chk((sn[k] & run) == (~so[k] & run), "R6 complement", sn[k] & run, ~so[k] & run);
            end
            if (run != 8'h00) begin
                tr = 0; consec = 0; inph = 1;
                for (int k = 0; k < 8; k++) begin
                    if ((so[k] & run) != 8'h00 && (so[k] & run) != run) inph = 0;
                    if (k > 0 && (so[k] & run) != (so[k-1] & run)) begin
                        tr++;
                        if (k > 1 && (so[k-1] & run) != (so[k-2] & run)) consec = 1;
                    end
                end
                chk(inph, "R6 in phase", 0, 1);
                if (VEC[r][18])
                    chk(tr == 7, "R6 full rate", tr, 7);
                else
                    chk((tr == 3 || tr == 4) && !consec, "R7 half rate", tr, 4);
            end
        end

        // R8: toggle stop around pair 0 in both rates and both stopped states
        for (int m = 0; m < 4; m++) begin
            @(posedge clk); #1;
            apply(VEC[0]);
            cfg_stop_en  = 8'h01;
            cfg_div_n    = m[0];
            cfg_stop_tri = m[1];
            half = m[0] ? 1 : 2;
            repeat (12) @(posedge clk);
            #1 mon_on = 1;
            for (int i = 0; i < 16; i++) begin
                repeat ((i * 3) % 7 + 1) @(posedge clk);
                #1.3 stop_pin = ~stop_pin;
            end
            repeat (12) @(posedge clk);
            #1 mon_on = 0;
            @(negedge clk);
            chk(drive_en[1] == 1'b1, "R3 ineligible pair runs", drive_en[1], 1);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule